// File: doc/BRIEF.md
# Trigger-Latching Pipeline Capture Buffer

This block writes one 32-bit input word into a circular pipeline memory on every clock cycle. Sampling never pauses. When an external trigger arrives, the block copies a short run of consecutive pipeline words into a multi-event FIFO. The copied run starts at a programmable distance back in time. The host later reads the captured windows out of the FIFO one word at a time.

The host sets the look-back distance through a load port. It turns capture on, and turns the busy output on, with a single configuration write. It reads out data by watching the not-empty status and popping words until that status clears.

A trigger may arrive when the FIFO has too little room for a full window. Such a trigger is dropped whole, and an overflow flag is raised. Capture then halts until the host has emptied the FIFO and enabled capture again.

Top module: `cap_pipe_buffer`

## Requirements
- R1: A trigger sampled at cycle t, with look-back L, stores the words sampled at cycles t-L-1, t-L and t-L+1, in that order. L=0 gives the words right around the trigger.
- R2: The look-back is loaded when `ld_mode` and `ld_strobe` are both high, as 255 minus `ld_val`. Reset sets L to 0. L=255 reaches back to the word sampled 256 cycles before the trigger.
- R3: A strobe on `ld_strobe` while `ld_mode` is low leaves the look-back unchanged.
- R4: After reset, capture is disabled and triggers are ignored. A write on `cfg_we` sets capture on from `cfg_acq_en` (bit `st_acq`).
- R5: Every accepted trigger stores exactly 3 words, one per cycle in the 3 cycles after the trigger. Triggers 4 cycles apart are both stored, and sampling carries on throughout.
- R6: A trigger that arrives while a window is still being copied is ignored.
- R7: The FIFO holds 255 words, which is 85 windows, without loss.
- R8: A trigger arriving with capture on but fewer than 3 free FIFO words is dropped whole. It sets `st_overflow` and clears `st_acq`.
- R9: While the overflow flag is set, enable writes are refused. The flag clears one cycle after the FIFO count reaches zero. A later enable write then resumes capture.
- R10: `rd_word` shows the oldest stored word whenever `st_nonempty` is high, and `rd_pop` removes it. A pop on an empty FIFO does nothing.
- R11: `busy_out` is high exactly when the overflow flag is set and the busy enable (`cfg_busy_en`, latched on `cfg_we`) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, also used by the host side |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 32 | Word sampled into the pipeline every cycle |
| trig | input | 1 | External trigger, one cycle per event |
| ld_mode | input | 1 | Load mode for the look-back register |
| ld_strobe | input | 1 | Load strobe, effective only in load mode |
| ld_val | input | 8 | Value written; look-back = 255 - ld_val |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_acq_en | input | 1 | Capture enable written on cfg_we |
| cfg_busy_en | input | 1 | Busy output enable written on cfg_we |
| rd_pop | input | 1 | Remove the oldest FIFO word |
| rd_word | output | 32 | Oldest FIFO word (first-word fall-through) |
| st_nonempty | output | 1 | FIFO holds at least one word |
| st_overflow | output | 1 | A trigger was dropped for lack of room |
| st_acq | output | 1 | Capture is enabled |
| busy_out | output | 1 | External busy, overflow gated by its enable |

## Verification
The bench uses the default build: a 255-word FIFO, a 3-word window and a 255 maximum look-back. With these values, 85 windows fill the FIFO exactly, so the 86th trigger hits the drop path at a realistic size. A 512-entry ring is derived from the maximum look-back, which makes the deepest reach of 256 cycles back observable against a counter-valued input. In a random phase, look-back loads, triggers, pops and enable writes are mixed against a reference queue. This reaches same-cycle pops and pushes, as well as refused enables while the overflow flag is set.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    localparam int CAP_WORD_W   = 32;
    localparam int CAP_MAX_LB   = 255;
    localparam int CAP_WINDOW   = 3;
    localparam int CAP_N_EVENTS = 85;

    // Ring must still hold the oldest word when the last word of a window is copied.
    function automatic int cap_ring_aw(input int max_lb, input int window);
        return $clog2(max_lb + window + 2);
    endfunction
endpackage

// File: rtl/cap_ring.sv
`timescale 1ns/1ps
module cap_ring #(
    parameter int W  = 32,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic [AW-1:0] wr_ptr
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q;

    always_comb begin
        wp_d = wp_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= wp_d;
    end

    always_ff @(posedge clk) begin
        if (rst_n) mem[wp_q] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
    assign wr_ptr  = wp_q;
endmodule

// File: rtl/cap_fifo.sv
`timescale 1ns/1ps
module cap_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        f_d     = f_q;
        do_pop  = pop  && (f_q.cnt != '0);
        do_push = push && (f_q.cnt != CW'(DEPTH));
        if (do_push) f_d.wp = nxt(f_q.wp);
        if (do_pop)  f_d.rp = nxt(f_q.rp);
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wp] <= push_data;
    end

    assign head  = mem[f_q.rp];
    assign count = f_q.cnt;
endmodule

// File: rtl/cap_ctrl.sv
`timescale 1ns/1ps
module cap_ctrl #(
    parameter int AW         = 9,
    parameter int LBW        = 8,
    parameter int CW         = 8,
    parameter int FIFO_DEPTH = 255,
    parameter int WINDOW     = 3,
    parameter int MAX_LB     = 255
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig,
    input  logic [AW-1:0]  wr_ptr,
    input  logic [CW-1:0]  fifo_cnt,
    input  logic           cfg_we,
    input  logic           cfg_acq_en,
    input  logic           cfg_busy_en,
    input  logic           ld_mode,
    input  logic           ld_strobe,
    input  logic [LBW-1:0] ld_val,
    output logic           push,
    output logic [AW-1:0]  rd_addr,
    output logic           acq,
    output logic           busy_en,
    output logic           ovf
);
    localparam int XW = $clog2(WINDOW+1);
    localparam logic [CW-1:0] ROOM_LIMIT = CW'(FIFO_DEPTH - WINDOW);

    typedef struct packed {
        logic           acq;
        logic           busy_en;
        logic           ovf;
        logic [LBW-1:0] lb;
        logic [XW-1:0]  xcnt;
        logic [AW-1:0]  rptr;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        // window copy in progress: one word per cycle
        if (s_q.xcnt != '0) begin
            push       = 1'b1;
            s_d.xcnt   = s_q.xcnt - XW'(1);
            s_d.rptr   = s_q.rptr + AW'(1);
        end
        if (cfg_we) begin
            s_d.acq     = cfg_acq_en & ~s_q.ovf;
            s_d.busy_en = cfg_busy_en;
        end
        if (trig && s_q.acq && (s_q.xcnt == '0)) begin
            if (fifo_cnt <= ROOM_LIMIT) begin
                s_d.xcnt = XW'(WINDOW);
                s_d.rptr = wr_ptr - AW'(s_q.lb) - AW'(1);
            end else begin
                s_d.ovf = 1'b1;
                s_d.acq = 1'b0;
            end
        end
        if (s_q.ovf && (fifo_cnt == '0)) s_d.ovf = 1'b0;
        if (ld_mode && ld_strobe) s_d.lb = LBW'(MAX_LB) - ld_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr = s_q.rptr;
    assign acq     = s_q.acq;
    assign busy_en = s_q.busy_en;
    assign ovf     = s_q.ovf;
endmodule

// File: rtl/cap_pipe_buffer.sv
`timescale 1ns/1ps
module cap_pipe_buffer
    import cap_pkg::*;
#(
    parameter int W          = CAP_WORD_W,
    parameter int MAX_LB     = CAP_MAX_LB,
    parameter int WINDOW     = CAP_WINDOW,
    parameter int N_EVENTS   = CAP_N_EVENTS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_in,
    input  logic         trig,
    input  logic         ld_mode,
    input  logic         ld_strobe,
    input  logic [$clog2(MAX_LB+1)-1:0] ld_val,
    input  logic         cfg_we,
    input  logic         cfg_acq_en,
    input  logic         cfg_busy_en,
    input  logic         rd_pop,
    output logic [W-1:0] rd_word,
    output logic         st_nonempty,
    output logic         st_overflow,
    output logic         st_acq,
    output logic         busy_out
);
    localparam int FIFO_DEPTH = WINDOW * N_EVENTS;
    localparam int AW         = cap_ring_aw(MAX_LB, WINDOW);
    localparam int LBW        = $clog2(MAX_LB+1);
    localparam int CW         = $clog2(FIFO_DEPTH+1);

    logic [AW-1:0] wr_ptr, rd_addr;
    logic [W-1:0]  ring_word;
    logic [CW-1:0] fifo_cnt;
    logic          push, busy_en, ovf;

    cap_ring #(.W(W), .AW(AW)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_data(smp_in),
        .rd_addr(rd_addr), .rd_data(ring_word), .wr_ptr(wr_ptr)
    );

    cap_ctrl #(.AW(AW), .LBW(LBW), .CW(CW), .FIFO_DEPTH(FIFO_DEPTH),
               .WINDOW(WINDOW), .MAX_LB(MAX_LB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .wr_ptr(wr_ptr),
        .fifo_cnt(fifo_cnt), .cfg_we(cfg_we), .cfg_acq_en(cfg_acq_en),
        .cfg_busy_en(cfg_busy_en), .ld_mode(ld_mode), .ld_strobe(ld_strobe),
        .ld_val(ld_val), .push(push), .rd_addr(rd_addr), .acq(st_acq),
        .busy_en(busy_en), .ovf(ovf)
    );

    cap_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(ring_word),
        .pop(rd_pop), .head(rd_word), .count(fifo_cnt)
    );

    assign st_nonempty = (fifo_cnt != '0);
    assign st_overflow = ovf;
    assign busy_out    = ovf & busy_en;
endmodule

// File: rtl/cap_pipe_buffer_chk.sv
`timescale 1ns/1ps
module cap_pipe_buffer_chk #(
    parameter int FIFO_DEPTH = 255,
    parameter int CW         = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          st_acq,
    input logic          st_overflow,
    input logic          st_nonempty,
    input logic          busy_out,
    input logic [CW-1:0] fifo_cnt
);
    // R4
    acq_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_acq) |-> $past(cfg_we));
    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(FIFO_DEPTH));
    // R8
    ovf_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_overflow) |-> st_nonempty);
    // R9
    ovf_blocks_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_overflow |-> !st_acq);
    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overflow && st_nonempty) |=> st_overflow);
    // R11
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_out |-> st_overflow);
endmodule

bind cap_pipe_buffer cap_pipe_buffer_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .st_acq(st_acq),
    .st_overflow(st_overflow), .st_nonempty(st_nonempty),
    .busy_out(busy_out), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_cap_pipe_buffer.sv
`timescale 1ns/1ps
module sim_cap_pipe_buffer;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [31:0] smp_in = '0;
    logic        trig = 0, ld_mode = 0, ld_strobe = 0, cfg_we = 0;
    logic        cfg_acq_en = 0, cfg_busy_en = 0, rd_pop = 0;
    logic [7:0]  ld_val = '0;
    logic [31:0] rd_word;
    logic        st_nonempty, st_overflow, st_acq, busy_out;

    cap_pipe_buffer u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .trig(trig),
        .ld_mode(ld_mode), .ld_strobe(ld_strobe), .ld_val(ld_val),
        .cfg_we(cfg_we), .cfg_acq_en(cfg_acq_en), .cfg_busy_en(cfg_busy_en),
        .rd_pop(rd_pop), .rd_word(rd_word), .st_nonempty(st_nonempty),
        .st_overflow(st_overflow), .st_acq(st_acq), .busy_out(busy_out)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit use_ctr = 1'b1;
    logic [31:0] hist [1024];

    // reference model state
    logic [31:0] mq[$];
    int  m_pend = 0, m_pidx = 0, m_lb = 0;
    bit  m_acq = 0, m_ovf = 0, m_ben = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mdl();
        int  psz = mq.size();
        bit  pacq = m_acq, povf = m_ovf;
        int  ppend = m_pend;
        bit  dpush = 0;
        logic [31:0] w = '0;
        if (m_pend > 0) begin
            w = hist[m_pidx % 1024]; dpush = 1; m_pidx++; m_pend--;
        end
        if (rd_pop && psz > 0) void'(mq.pop_front());
        if (dpush) mq.push_back(w);
        if (cfg_we) begin m_acq = cfg_acq_en && !povf; m_ben = cfg_busy_en; end
        if (trig && pacq && ppend == 0) begin
            if (255 - psz >= 3) begin m_pend = 3; m_pidx = cyc - m_lb - 1; end
            else begin m_ovf = 1; m_acq = 0; end
        end
        if (povf && psz == 0) m_ovf = 0;
        if (ld_mode && ld_strobe) m_lb = 255 - int'(ld_val);
    endtask

    task automatic tick();
        smp_in = use_ctr ? 32'(cyc) : $urandom;
        hist[cyc % 1024] = smp_in;
        @(posedge clk); #1;
        mdl();
        chk(st_nonempty == (mq.size() != 0), "R10 nonempty", 32'(st_nonempty), 32'(mq.size() != 0));
        if (mq.size() != 0) chk(rd_word == mq[0], "R1 head word", rd_word, mq[0]);
        chk(st_overflow == m_ovf, "R8 overflow flag", 32'(st_overflow), 32'(m_ovf));
        chk(st_acq == m_acq, "R4 acq flag", 32'(st_acq), 32'(m_acq));
        chk(busy_out == (m_ovf & m_ben), "R11 busy", 32'(busy_out), 32'(m_ovf & m_ben));
        cyc++;
        @(negedge clk);
        trig = 0; cfg_we = 0; ld_strobe = 0; rd_pop = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic fire(output int t);
        trig = 1; t = cyc; tick();
    endtask

    task automatic read_word(input logic [31:0] exp, input string tag);
        chk(rd_word == exp && st_nonempty, tag, rd_word, exp);
        rd_pop = 1; tick();
    endtask

    task automatic load_lb(input logic [7:0] v);
        ld_mode = 1; ld_val = v; ld_strobe = 1; tick(); ld_mode = 0;
    endtask

    task automatic enable(input bit a, input bit b);
        cfg_we = 1; cfg_acq_en = a; cfg_busy_en = b; tick();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t, t0, n;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk(!st_nonempty && !st_overflow && !st_acq && !busy_out, "R4 reset state",
            {28'd0, st_nonempty, st_overflow, st_acq, busy_out}, 32'd0);
        ticks(600);
        // R4: triggers ignored while disabled
        fire(t); ticks(5);
        chk(!st_nonempty, "R4 trigger ignored when disabled", 32'(st_nonempty), 0);
        enable(1, 1);
        chk(st_acq, "R4 enable write", 32'(st_acq), 1);
        // R1 with L=0 after reset (R2 reset value)
        fire(t); ticks(4);
        read_word(t-1, "R1 L0 w0"); read_word(t, "R1 L0 w1"); read_word(t+1, "R2 L0 w2");
        // R2 load L=10, R3 strobe without mode ignored
        load_lb(8'd245);
        ld_mode = 0; ld_val = 8'd0; ld_strobe = 1; tick();
        fire(t); ticks(4);
        read_word(t-11, "R3 L10 w0"); read_word(t-10, "R2 L10 w1"); read_word(t-9, "R2 L10 w2");
        // R2 deepest look-back
        load_lb(8'd0);
        fire(t); ticks(4);
        read_word(t-256, "R2 L255 w0"); read_word(t-255, "R2 L255 w1"); read_word(t-254, "R2 L255 w2");
        // R6 trigger during copy ignored
        load_lb(8'd255);
        fire(t); tick(); trig = 1; tick(); ticks(4);
        read_word(t-1, "R6 w0"); read_word(t, "R6 w1"); read_word(t+1, "R6 w2");
        chk(!st_nonempty, "R6 only one window", 32'(st_nonempty), 0);
        // R5 triggers 4 cycles apart
        fire(t); ticks(3); fire(t0); ticks(4);
        chk(t0 == t + 4, "R5 spacing", t0, t + 4);
        read_word(t-1, "R5 a0"); read_word(t, "R5 a1"); read_word(t+1, "R5 a2");
        read_word(t0-1, "R5 b0"); read_word(t0, "R5 b1"); read_word(t0+1, "R5 b2");
        // R7 fill 85 windows
        fire(t0); ticks(3);
        for (int k = 1; k < 85; k++) begin fire(t); ticks(3); end
        chk(!st_overflow && st_acq, "R7 85 windows fit", {st_overflow, st_acq}, 32'd1);
        // R8 86th dropped
        fire(t); ticks(3);
        chk(st_overflow, "R8 overflow set", 32'(st_overflow), 1);
        chk(!st_acq, "R8 acq cleared", 32'(st_acq), 0);
        chk(busy_out, "R11 busy asserted", 32'(busy_out), 1);
        enable(1, 1);
        chk(!st_acq, "R9 enable refused", 32'(st_acq), 0);
        trig = 1; tick(); ticks(3);
        chk(rd_word == t0 - 1, "R7 oldest word kept", rd_word, t0 - 1);
        n = 0;
        while (st_nonempty && n < 400) begin rd_pop = 1; tick(); n++; end
        chk(n == 255, "R7 stored word count", n, 255);
        chk(st_overflow, "R9 flag held until clear cycle", 32'(st_overflow), 1);
        tick();
        chk(!st_overflow && !busy_out, "R9 overflow cleared", {st_overflow, busy_out}, 0);
        enable(1, 0);
        chk(st_acq, "R9 capture resumes", 32'(st_acq), 1);
        // R10 pop on empty ignored
        rd_pop = 1; tick();
        fire(t); ticks(4);
        read_word(t-1, "R10 after empty pop w0"); read_word(t, "R10 w1"); read_word(t+1, "R10 w2");
        // random phase
        use_ctr = 0;
        for (int i = 0; i < 4000; i++) begin
            trig   = ($urandom % 5) == 0;
            rd_pop = ($urandom % 3) == 0;
            if (($urandom % 97) == 0) begin cfg_we = 1; cfg_acq_en = 1; cfg_busy_en = $urandom; end
            if (($urandom % 151) == 0) begin ld_mode = 1; ld_strobe = 1; ld_val = $urandom; end
            else ld_mode = $urandom % 2;
            if (($urandom % 300) == 0) begin rd_pop = 0; trig = 1; end
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial void'($urandom(32'd7341));
endmodule